// File: doc/BRIEF.md
# Serial Flash Subsector Erase Controller

This block is the command side of a serial flash device. It listens on a single serial data line while chip select is low. It handles three commands: arming writes, reading status and erasing one subsector. Serial clock, chip select and data in are assumed to be already synchronous to the system clock. The block finds serial clock rising edges by comparing each sample with the one before, and it shifts all bits most significant first.

An erase needs two things. First, a write-enable frame must have set the write-enable flag. Second, an erase frame must end exactly on its last address bit. If a frame ends at any other bit count, or while an erase is running, or on a protected sector, it is dropped without any effect. When an erase is accepted, the block pulses one request to the memory array with the subsector base address. It holds the in-progress flag for a fixed number of clock cycles. It also clears the write-enable flag. A status read returns the flags, and it repeats the status byte for as long as chip select stays low.

Top module: `sflash_erase_ctrl`

## Requirements
- R1: After reset, erase_req_o is 0, sdo_o is 0, and a status read returns 00h.
- R2: The write-enable opcode 06h sets the write-enable flag. Status bit 1 reads 1 only when chip select rises after exactly 8 bits. A frame of any other length leaves the flag unchanged.
- R3: The status-read opcode 05h makes sdo_o return the byte {6'b0, write_enable, in_progress} MSB first. The value is updated on each serial clock rising edge. The byte repeats while chip select is low, and sdo_o returns to 0 once chip select is high.
- R4: An erase frame is opcode 20h followed by three address bytes. When chip select rises after exactly 32 bits, with the write-enable flag set, no erase running and the sector not protected, erase_req_o is high for one clock cycle. That cycle is the one after the clock edge that samples chip select high.
- R5: erase_addr_o equals the received address with bit 23 cleared and bits 11:0 cleared. Any offset inside a 4 KiB subsector selects the same subsector.
- R6: Status bit 0 (in progress) reads 1 from the start of an erase and stays 1 for ERASE_CYCLES clock cycles. It then reads 0.
- R7: Starting an erase clears the write-enable flag.
- R8: If chip select rises after any bit count other than 32, the erase frame is discarded. No request is issued and the write-enable flag keeps its value.
- R9: An erase frame that arrives while the write-enable flag is clear issues no request.
- R10: An erase whose sector index (address bits 22:16) has its bit set in prot_i is rejected. No request is issued and the write-enable flag keeps its value.
- R11: An erase frame that arrives while an erase is running is rejected. The running cycle keeps its original end time.
- R12: A write-enable frame that arrives while an erase is running does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, synchronous to clk_i |
| sck_i | input | 1 | Serial clock, sampled by clk_i |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Serial data out (status byte) |
| prot_i | input | NUM_SEC (128) | Per-sector erase protection mask |
| erase_req_o | output | 1 | One-cycle erase request to the array |
| erase_addr_o | output | ADDR_W (24) | Subsector base address of the request |

## Verification
The bench uses the default address geometry: 24-bit addresses, 4 KiB subsectors and 64 KiB sectors. This lets real offsets, a set bit 23 and a protected sector index appear in the address byte stream. ERASE_CYCLES is set to 400, which is longer than a complete serial frame, so a second erase frame and a second write-enable frame can arrive while the first erase is still running. The value is still short enough that the bench can read status just before the planned end of the cycle and again just after it. This shows whether the cycle ended on time or was stretched by the rejected command.

// File: rtl/sflash_erase_pkg.sv
package sflash_erase_pkg;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_RD_STAT   = 8'h05;
  localparam logic [7:0] OP_SUB_ERASE = 8'h20;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_WEN_BIT  = 1;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/sflash_erase_shift.sv
module sflash_erase_shift #(
  parameter int BCNT_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sck_i,
  input  logic                  sdi_i,
  output logic                  rise_o,
  output logic                  cs_rise_o,
  output logic                  byte_vld_o,
  output sflash_erase_pkg::byte_t byte_o,
  output logic [BCNT_W-1:0]     bit_cnt_o
);
  localparam logic [BCNT_W-1:0] CNT_MAX = '1;

  logic              sck_q, cs_q;
  logic [6:0]        sh_q;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic              sat;

  assign sat        = (bit_cnt_q == CNT_MAX);
  assign rise_o     = sck_i & ~sck_q & ~cs_ni;
  assign cs_rise_o  = cs_ni & ~cs_q;
  assign byte_vld_o = rise_o && (bit_cnt_q[2:0] == 3'd7) && !sat;
  assign byte_o     = {sh_q, sdi_i};
  assign bit_cnt_o  = bit_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      sh_q      <= '0;
      bit_cnt_q <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (rise_o) sh_q <= {sh_q[5:0], sdi_i};
      if (cs_ni)                bit_cnt_q <= '0;
      else if (rise_o && !sat)  bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // R8: counter is idle whenever the frame is closed
  a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_cnt_q == '0));
endmodule

// File: rtl/sflash_erase_decode.sv
module sflash_erase_decode #(
  parameter int ADDR_W  = 24,
  parameter int SUB_LSB = 12,
  parameter int SEC_LSB = 16,
  parameter int BCNT_W  = 6,
  parameter int NUM_SEC = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    rise_i,
  input  logic                    cs_rise_i,
  input  logic                    byte_vld_i,
  input  sflash_erase_pkg::byte_t byte_i,
  input  logic [BCNT_W-1:0]       bit_cnt_i,
  input  logic                    busy_i,
  input  logic [NUM_SEC-1:0]      prot_i,
  output logic                    start_o,
  output logic [ADDR_W-1:0]       base_o,
  output logic                    sdo_o
);
  import sflash_erase_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int FRAME_BITS = 8 * (1 + ADDR_BYTES);
  localparam int IDX_W      = BCNT_W - 3;
  localparam int SEC_IDX_W  = ADDR_W - 1 - SEC_LSB;
  localparam logic [ADDR_W-1:0] BASE_MASK =
    {1'b0, {(ADDR_W-1-SUB_LSB){1'b1}}, {SUB_LSB{1'b0}}};

  byte_t             op_q, tx_sh_q, stat;
  logic [ADDR_W-1:0] addr_q;
  logic              wel_q, rd_act_q;
  logic [2:0]        tx_cnt_q;
  logic [IDX_W-1:0]  byte_idx;
  logic [SEC_IDX_W-1:0] sec_idx;
  logic              wen_hit, ers_hit, rd_open;

  assign byte_idx = bit_cnt_i[BCNT_W-1:3];
  assign base_o   = addr_q & BASE_MASK;
  assign sec_idx  = base_o[ADDR_W-2:SEC_LSB];

  always_comb begin
    stat = '0;
    stat[STAT_BUSY_BIT] = busy_i;
    stat[STAT_WEN_BIT]  = wel_q;
  end

  assign wen_hit = cs_rise_i && (op_q == OP_WR_EN) && (bit_cnt_i == BCNT_W'(8)) && !busy_i;
  assign ers_hit = cs_rise_i && (op_q == OP_SUB_ERASE) && (bit_cnt_i == BCNT_W'(FRAME_BITS))
                   && wel_q && !busy_i && !prot_i[sec_idx];
  assign start_o = ers_hit;
  assign rd_open = byte_vld_i && (byte_idx == '0) && (byte_i == OP_RD_STAT);
  assign sdo_o   = rd_act_q & tx_sh_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      addr_q <= '0;
      wel_q  <= 1'b0;
    end else begin
      if (byte_vld_i && byte_idx == '0) op_q <= byte_i;
      if (byte_vld_i && byte_idx != '0 && byte_idx <= IDX_W'(ADDR_BYTES))
        addr_q <= {addr_q[ADDR_W-9:0], byte_i};
      if (ers_hit)      wel_q <= 1'b0;
      else if (wen_hit) wel_q <= 1'b1;
    end
  end

  // status shifter: present MSB, shift on each rising edge, reload live status per byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      tx_sh_q  <= '0;
      tx_cnt_q <= '0;
    end else begin
      if (cs_ni)        rd_act_q <= 1'b0;
      else if (rd_open) rd_act_q <= 1'b1;
      if (rd_open) begin
        tx_sh_q  <= stat;
        tx_cnt_q <= '0;
      end else if (rd_act_q && rise_i) begin
        if (tx_cnt_q == 3'd7) begin
          tx_sh_q  <= stat;
          tx_cnt_q <= '0;
        end else begin
          tx_sh_q  <= {tx_sh_q[6:0], 1'b0};
          tx_cnt_q <= tx_cnt_q + 1'b1;
        end
      end
    end
  end

  a_r7_wel_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !wel_q);
  a_r12_wel_idle_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(!busy_i));
  a_r3_sdo_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sdo_o);
endmodule

// File: rtl/sflash_erase_timer.sv
module sflash_erase_timer #(
  parameter int ADDR_W       = 24,
  parameter int ERASE_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      req_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      req_o <= start_i;
      if (start_i) begin
        cnt_q  <= CNT_W'(ERASE_CYCLES);
        addr_o <= base_i;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r4_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
  a_r6_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);
endmodule

// File: rtl/sflash_erase_ctrl.sv
module sflash_erase_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int SUB_LSB      = 12,
  parameter int SEC_LSB      = 16,
  parameter int ERASE_CYCLES = 1000000,
  parameter int NUM_SEC      = 1 << (ADDR_W - 1 - SEC_LSB)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic [NUM_SEC-1:0] prot_i,
  output logic               erase_req_o,
  output logic [ADDR_W-1:0]  erase_addr_o
);
  localparam int FRAME_BITS = 8 * (1 + ADDR_W / 8);
  localparam int BCNT_W     = $clog2(FRAME_BITS * 2);

  logic                    rise, cs_rise, byte_vld, start, busy;
  sflash_erase_pkg::byte_t byte_val;
  logic [BCNT_W-1:0]       bit_cnt;
  logic [ADDR_W-1:0]       base;

  sflash_erase_shift #(.BCNT_W(BCNT_W)) i_shift (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i,
    .rise_o(rise), .cs_rise_o(cs_rise), .byte_vld_o(byte_vld),
    .byte_o(byte_val), .bit_cnt_o(bit_cnt)
  );

  sflash_erase_decode #(
    .ADDR_W(ADDR_W), .SUB_LSB(SUB_LSB), .SEC_LSB(SEC_LSB),
    .BCNT_W(BCNT_W), .NUM_SEC(NUM_SEC)
  ) i_decode (
    .clk_i, .rst_ni, .cs_ni,
    .rise_i(rise), .cs_rise_i(cs_rise), .byte_vld_i(byte_vld), .byte_i(byte_val),
    .bit_cnt_i(bit_cnt), .busy_i(busy), .prot_i,
    .start_o(start), .base_o(base), .sdo_o
  );

  sflash_erase_timer #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)) i_timer (
    .clk_i, .rst_ni, .start_i(start), .base_i(base),
    .busy_o(busy), .req_o(erase_req_o), .addr_o(erase_addr_o)
  );
endmodule

// File: tb/test_sflash_erase_ctrl.sv
module test_sflash_erase_ctrl;
  localparam int ERASE_CYCLES = 400;
  localparam int ADDR_W = 24;

  logic clk_i = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, sck_i = 1'b0, sdi_i = 1'b0;
  logic sdo_o, erase_req_o;
  logic [127:0] prot_i;
  logic [ADDR_W-1:0] erase_addr_o;

  int errors = 0, checks = 0, cyc = 0, req_cnt = 0;
  bit done = 0;
  logic wel_m;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (erase_req_o) req_cnt <= req_cnt + 1;
  end

  sflash_erase_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) i_sflash_erase_ctrl (.*);

  // {wren, nbits[5:0], addr[23:0], exp_req, exp_addr[23:0]}
  localparam logic [55:0] VEC [8] = '{
    {1'b1, 6'd32, 24'h012345, 1'b1, 24'h012000},
    {1'b1, 6'd32, 24'h812FFF, 1'b1, 24'h012000},
    {1'b0, 6'd32, 24'h030000, 1'b0, 24'h000000},
    {1'b1, 6'd32, 24'h05A000, 1'b0, 24'h000000},
    {1'b1, 6'd31, 24'h031000, 1'b0, 24'h000000},
    {1'b1, 6'd33, 24'h031000, 1'b0, 24'h000000},
    {1'b1, 6'd32, 24'h7FF800, 1'b1, 24'h7FF000},
    {1'b1, 6'd24, 24'h031000, 1'b0, 24'h000000}
  };
  string vtag [8] = '{"R4", "R5", "R9", "R10", "R8", "R8", "R4", "R8"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b);
    sdi_i = b; tick(2); sck_i = 1'b1; tick(2); sck_i = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [23:0] addr, input int nbits);
    logic [31:0] v;
    v = {op, addr};
    cs_ni = 1'b0; tick(2);
    for (int i = 0; i < nbits; i++) send_bit(i < 32 ? v[31-i] : 1'b0);
  endtask

  task automatic close_chk(input logic exp_req, input logic [23:0] exp_addr, input string tag);
    cs_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(erase_req_o === exp_req, tag, erase_req_o, exp_req);
    if (exp_req) chk(erase_addr_o === exp_addr, tag, erase_addr_o, exp_addr);
    tick(4);
  endtask

  task automatic wren(input int nbits);
    send_frame(8'h06, 24'h0, nbits);
    close_chk(1'b0, 24'h0, "R2");
  endtask

  task automatic read_stat(input int nbytes, output logic [15:0] res);
    res = '0;
    send_frame(8'h05, 24'h0, 8);
    for (int i = 0; i < nbytes * 8; i++) begin
      sdi_i = 1'b0; tick(2);
      res = {res[14:0], sdo_o};
      sck_i = 1'b1; tick(2); sck_i = 1'b0;
    end
    cs_ni = 1'b1; tick(2);
    chk(sdo_o === 1'b0, "R3", sdo_o, 0);
    tick(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] st;
    int t0;
    prot_i = '0;
    prot_i[5] = 1'b1;
    tick(4); rst_ni = 1'b1; tick(2);
    // R1 reset state
    chk(erase_req_o === 1'b0, "R1", erase_req_o, 0);
    chk(sdo_o === 1'b0, "R1", sdo_o, 0);
    read_stat(1, st);
    chk(st[7:0] === 8'h00, "R1", st, 8'h00);

    // R2: wrong length does not arm
    wren(9);
    read_stat(1, st);
    chk(st[7:0] === 8'h00, "R2", st, 8'h00);
    wren(8);
    // R3: repeated status byte
    read_stat(2, st);
    chk(st === 16'h0202, "R3", st, 16'h0202);
    wel_m = 1'b1;

    for (int k = 0; k < 8; k++) begin
      logic [55:0] v;
      v = VEC[k];
      if (v[55]) begin wren(8); wel_m = 1'b1; end
      send_frame(8'h20, v[48:25], int'(v[54:49]));
      close_chk(v[24], v[23:0], vtag[k]);
      if (v[24]) wel_m = 1'b0; // R7
      read_stat(1, st);
      chk(st[7:0] === {6'b0, wel_m, v[24]}, v[24] ? "R7" : vtag[k], st, {6'b0, wel_m, v[24]});
      if (v[24]) tick(ERASE_CYCLES);
    end

    // R11 / R12 / R6: commands during a running erase
    wren(8);
    send_frame(8'h20, 24'h100000, 32);
    t0 = cyc;
    close_chk(1'b1, 24'h100000, "R4");
    read_stat(1, st);
    chk(st[7:0] === 8'h01, "R6", st, 8'h01);
    wren(8);
    read_stat(1, st);
    chk(st[7:0] === 8'h01, "R12", st, 8'h01);
    send_frame(8'h20, 24'h200000, 32);
    close_chk(1'b0, 24'h0, "R11");
    while (cyc < t0 + ERASE_CYCLES - 60) tick(1);
    read_stat(1, st);
    chk(st[7:0] === 8'h01, "R6", st, 8'h01);
    while (cyc < t0 + ERASE_CYCLES + 8) tick(1);
    read_stat(1, st);
    chk(st[7:0] === 8'h00, "R11", st, 8'h00);

    chk(req_cnt == 4, "R4", req_cnt, 4);
    finish_run();
  end
endmodule